// File: doc/BRIEF.md
# Phone-Line Link Integrity Monitor

This block keeps the link-status indication for a home phone-line network PHY and schedules keep-alive transmissions toward the far end. A version-select input picks one of two behaviours. In legacy mode the link is reported as permanently up. In the newer mode the link is up only while packets keep arriving, and it falls after a multi-second receive silence.

In the newer mode the block also watches the local transmit path. If no packet has left for a set interval, it raises a request asking the transmit path for a short runt or minimum-size packet, so that the far end's own link check stays satisfied. Software can raise the same request at any time and in either mode. The request is a level that stays up until the transmit path reports a sent packet.

All time intervals are counted in pulses of a 1 ms tick input, so a simulation can run them with a fast tick and small parameter values.

Top module: `phl_link_monitor`

## Requirements
- R1: While `verSel` is 0 (legacy mode), `linkUp` is 1 in every cycle.
- R2: After reset with `verSel` at 1, `linkUp` is 0 and `runtReq` is 0 until a packet is received or a request is raised.
- R3: In newer mode, `linkUp` stays 1 through SILENCE_MS tick pulses without a received packet, and falls to 0 on the tick pulse after that (SILENCE_MS+1 ticks of silence).
- R4: A `rxPkt` pulse makes `linkUp` 1 in the next cycle and restarts the silence count from zero.
- R5: In newer mode, `runtReq` rises on the KEEP_MS-th tick pulse after the last `txPkt` pulse (or after reset), and not before.
- R6: A `swRunt` pulse sets `runtReq` in the next cycle, in either mode.
- R7: Once set, `runtReq` stays 1 until a `txPkt` pulse arrives; ticks do not clear it.
- R8: A `txPkt` pulse clears `runtReq` in the next cycle and restarts the keep-alive count; when `swRunt` arrives in the same cycle, `runtReq` stays 1.
- R9: In legacy mode no automatic request is raised and the keep-alive count is held at zero, so after a switch to newer mode a full KEEP_MS ticks pass before the first automatic request.
- R10: When `rxPkt` and `msTick` arrive in the same cycle, the received packet wins: the silence count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| verSel | input | 1 | 0 = legacy mode, 1 = newer mode |
| rxPkt | input | 1 | One-cycle pulse per received packet |
| txPkt | input | 1 | One-cycle pulse per transmitted packet (acknowledges the request) |
| swRunt | input | 1 | One-cycle software command to send a runt |
| linkUp | output | 1 | Link status |
| runtReq | output | 1 | Level request to the transmit path for a runt packet |

## Verification
On every cycle the assertions check that legacy mode keeps the link up, that a received packet brings it up, that the link never falls without a tick, and the set, hold and clear rules of the runt request with software priority. The exact tick counts at which the link falls and at which the automatic request rises can only be shown by the bench's sweeps over the silence gap and the transmit gap, as can the restart of both counts and the behaviour across a mode switch.

// File: rtl/phl_pkg.sv
package phl_pkg;

  // Strobes from control to the counter datapath.
  typedef struct packed {
    logic clrSil;   // restart receive silence count
    logic incSil;   // advance receive silence count
    logic clrKeep;  // restart keep-alive count
    logic incKeep;  // advance keep-alive count
  } phl_strobe_t;

endpackage

// File: rtl/phl_counters.sv
module phl_counters
  import phl_pkg::*;
#(
  parameter int SILENCE_MS = 4000,
  parameter int KEEP_MS    = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  phl_strobe_t stb,
  output logic        silFull,
  output logic        keepNear,
  output logic        keepFull
);

  localparam int SIL_W  = $clog2(SILENCE_MS + 1);
  localparam int KEEP_W = $clog2(KEEP_MS + 1);
  localparam logic [SIL_W-1:0]  SIL_MAX   = SIL_W'(SILENCE_MS);
  localparam logic [KEEP_W-1:0] KEEP_MAX  = KEEP_W'(KEEP_MS);
  localparam logic [KEEP_W-1:0] KEEP_LAST = KEEP_W'(KEEP_MS - 1);

  logic [SIL_W-1:0]  silCnt;
  logic [KEEP_W-1:0] keepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      silCnt <= '0;
    end else if (stb.clrSil) begin
      silCnt <= '0;
    end else if (stb.incSil) begin
      silCnt <= silCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepCnt <= '0;
    end else if (stb.clrKeep) begin
      keepCnt <= '0;
    end else if (stb.incKeep) begin
      keepCnt <= keepCnt + 1'b1;
    end
  end

  assign silFull  = (silCnt == SIL_MAX);
  assign keepFull = (keepCnt == KEEP_MAX);
  assign keepNear = (keepCnt == KEEP_LAST);

endmodule

// File: rtl/phl_ctrl.sv
module phl_ctrl
  import phl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        msTick,
  input  logic        verSel,
  input  logic        rxPkt,
  input  logic        txPkt,
  input  logic        swRunt,
  input  logic        silFull,
  input  logic        keepNear,
  input  logic        keepFull,
  output phl_strobe_t stb,
  output logic        linkState,
  output logic        runtReq
);

  logic silTick;
  logic keepTick;
  logic silLapse;
  logic keepFire;

  // Receive silence: a packet always wins over a tick.
  assign silTick  = msTick && !rxPkt;
  assign silLapse = silTick && silFull;

  // Keep-alive only runs in newer mode; a sent packet wins over a tick.
  assign keepTick = msTick && verSel && !txPkt;
  assign keepFire = keepTick && keepNear;

  always_comb begin
    stb         = '0;
    stb.clrSil  = rxPkt;
    stb.incSil  = silTick && !silFull;
    stb.clrKeep = txPkt || !verSel;
    stb.incKeep = keepTick && !keepFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkState <= 1'b0;
    end else if (rxPkt) begin
      linkState <= 1'b1;
    end else if (silLapse) begin
      linkState <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runtReq <= 1'b0;
    end else if (swRunt || keepFire) begin
      runtReq <= 1'b1;
    end else if (txPkt) begin
      runtReq <= 1'b0;
    end
  end

endmodule

// File: rtl/phl_link_monitor.sv
module phl_link_monitor #(
  parameter int SILENCE_MS = 4000,
  parameter int KEEP_MS    = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic verSel,
  input  logic rxPkt,
  input  logic txPkt,
  input  logic swRunt,
  output logic linkUp,
  output logic runtReq
);

  import phl_pkg::*;

  phl_strobe_t stb;
  logic silFull;
  logic keepNear;
  logic keepFull;
  logic linkState;

  phl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .msTick   (msTick),
    .verSel   (verSel),
    .rxPkt    (rxPkt),
    .txPkt    (txPkt),
    .swRunt   (swRunt),
    .silFull  (silFull),
    .keepNear (keepNear),
    .keepFull (keepFull),
    .stb      (stb),
    .linkState(linkState),
    .runtReq  (runtReq)
  );

  phl_counters #(
    .SILENCE_MS(SILENCE_MS),
    .KEEP_MS   (KEEP_MS)
  ) u_counters (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .silFull (silFull),
    .keepNear(keepNear),
    .keepFull(keepFull)
  );

  assign linkUp = !verSel || linkState;

endmodule

// File: rtl/phl_link_monitor_chk.sv
module phl_link_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic msTick,
  input logic verSel,
  input logic rxPkt,
  input logic txPkt,
  input logic swRunt,
  input logic linkUp,
  input logic runtReq
);

  // R1: legacy mode reports the link up
  a_r1_legacy_up: assert property (@(posedge clk) disable iff (!rstN)
    !verSel |-> linkUp);

  // R4: a received packet brings the link up
  a_r4_rx_raises: assert property (@(posedge clk) disable iff (!rstN)
    rxPkt |=> linkUp);

  // R3: the link never falls in a cycle without a tick
  a_r3_no_drop_untimed: assert property (@(posedge clk) disable iff (!rstN)
    (verSel && linkUp && !msTick) |=> (!verSel || linkUp));

  // R6: software command sets the request
  a_r6_sw_sets: assert property (@(posedge clk) disable iff (!rstN)
    swRunt |=> runtReq);

  // R7: request held until a packet is sent
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (runtReq && !txPkt) |=> runtReq);

  // R8: a sent packet clears the request unless software asks again
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (txPkt && !swRunt) |=> !runtReq);

  // R5: an automatic request only rises on a tick in newer mode
  a_r5_auto_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!runtReq && !swRunt && !(msTick && verSel)) |=> !runtReq);

endmodule

bind phl_link_monitor phl_link_monitor_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .msTick (msTick),
  .verSel (verSel),
  .rxPkt  (rxPkt),
  .txPkt  (txPkt),
  .swRunt (swRunt),
  .linkUp (linkUp),
  .runtReq(runtReq)
);

// File: tb/test_phl_link_monitor.sv
module test_phl_link_monitor;

  localparam int SIL  = 12;
  localparam int KEEP = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic verSel = 1'b1;
  logic rxPkt = 1'b0;
  logic txPkt = 1'b0;
  logic swRunt = 1'b0;
  logic linkUp;
  logic runtReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phl_link_monitor #(.SILENCE_MS(SIL), .KEEP_MS(KEEP)) i_phl_link_monitor (
    .clk(clk), .rstN(rstN), .msTick(msTick), .verSel(verSel),
    .rxPkt(rxPkt), .txPkt(txPkt), .swRunt(swRunt),
    .linkUp(linkUp), .runtReq(runtReq)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
    end
  endtask

  task automatic pulseRx();
    @(negedge clk) rxPkt = 1'b1;
    @(negedge clk) rxPkt = 1'b0;
  endtask

  task automatic pulseTx();
    @(negedge clk) txPkt = 1'b1;
    @(negedge clk) txPkt = 1'b0;
  endtask

  task automatic pulseSw();
    @(negedge clk) swRunt = 1'b1;
    @(negedge clk) swRunt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 link after reset", linkUp, 1'b0);
    chk("R2 request after reset", runtReq, 1'b0);

    // Legacy mode: link forced up, keep-alive held
    verSel = 1'b0;
    @(negedge clk);
    chk("R1 legacy link", linkUp, 1'b1);
    ticks(KEEP + 3);
    chk("R9 no auto request in legacy", runtReq, 1'b0);
    chk("R1 legacy link after ticks", linkUp, 1'b1);

    // Switch to newer mode: full interval before request
    verSel = 1'b1;
    ticks(KEEP - 1);
    chk("R9 no request one tick early", runtReq, 1'b0);
    ticks(1);
    chk("R5 request after switch", runtReq, 1'b1);
    ticks(3);
    chk("R7 request held across ticks", runtReq, 1'b1);
    pulseTx();
    chk("R8 tx clears request", runtReq, 1'b0);

    // Silence sweep
    for (int gap = 0; gap <= SIL + 2; gap++) begin
      pulseRx();
      chk("R4 rx raises link", linkUp, 1'b1);
      ticks(gap);
      chk("R3 link after silence gap", linkUp, (gap <= SIL) ? 1'b1 : 1'b0);
      pulseTx();
    end

    // Keep-alive sweep
    for (int k = 0; k <= KEEP + 2; k++) begin
      pulseTx();
      chk("R8 request cleared by tx", runtReq, 1'b0);
      ticks(k);
      chk("R5 request after tx gap", runtReq, (k >= KEEP) ? 1'b1 : 1'b0);
    end
    pulseTx();

    // Software command in both modes
    pulseSw();
    chk("R6 software request newer", runtReq, 1'b1);
    pulseTx();
    verSel = 1'b0;
    pulseSw();
    chk("R6 software request legacy", runtReq, 1'b1);
    @(negedge clk) begin txPkt = 1'b1; swRunt = 1'b1; end
    @(negedge clk) begin txPkt = 1'b0; swRunt = 1'b0; end
    chk("R8 software wins over tx", runtReq, 1'b1);
    pulseTx();
    chk("R8 tx alone clears", runtReq, 1'b0);
    verSel = 1'b1;

    // Rx and tick together: rx restarts count
    pulseRx();
    ticks(SIL - 3);
    @(negedge clk) begin rxPkt = 1'b1; msTick = 1'b1; end
    @(negedge clk) begin rxPkt = 1'b0; msTick = 1'b0; end
    ticks(SIL);
    chk("R10 rx beats tick, still up", linkUp, 1'b1);
    ticks(1);
    chk("R10 drop after restarted count", linkUp, 1'b0);
    verSel = 1'b0;
    @(negedge clk);
    chk("R1 legacy overrides dropped link", linkUp, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule